// File: doc/BRIEF.md
# I2C Slave Address Match Detector

This block watches an I2C bus whose SCL and SDA lines have already been brought into the system clock domain, and decodes the first byte after every START condition. The eight bits are taken most significant bit first, one per rising SCL edge. Bit 0 is the read/write bit. The upper seven bits are compared with a programmable own-address register. The block also recognises extension codes, which are bytes whose top nibble is all zeros or all ones. The all-zero write byte is reported as a general call. When the byte is accepted, the block raises a one-cycle interrupt pulse.

Once it has been addressed, the block treats itself as taking part in the transfer. A local release input or a STOP condition withdraws it. While the local side is transmitting, each byte read back from SDA is compared with the byte that was meant to be sent, and any difference is latched as a transmit error. All status flags stay readable until the next START.

Top module: `i2c_addr_match`

## Requirements
- R1: Bits are taken MSB first on rising SCL edges. When bits [7:1] of the first byte after START equal bits [7:1] of the own-address register, the coincidence flag `coin_o` is set. The R/W bit (bit 0) takes no part in this comparison.
- R2: `irq_o` is high for exactly one system clock when an accepted address byte completes. It rises after the falling edge of the eighth SCL clock and not at the eighth rising edge.
- R3: When the upper four bits of the address byte are 0000 or 1111, `ext_o` is set and the interrupt fires even if the address does not match.
- R4: Received bytes never alter the own-address register. Only `sva_we_i` writes it, and it is read back on `sva_o`.
- R5: With the own address holding a 10-bit header of the form 11110xx0, a byte that matches only in its upper four bits sets `ext_o` with `coin_o` low. A byte that matches in all seven address bits sets both flags.
- R6: The byte 0x00 sets `gcall_o`. The byte 0x01 (same address, read) does not set `gcall_o`, but it still sets `ext_o`.
- R7: After a match or an extension code, `active_o` goes high. A byte that is neither gives no interrupt and leaves `active_o` low.
- R8: While `release_i` is high, `active_o` drops in the next cycle. Bytes after that are ignored, and no transmit check is made, until the next START.
- R9: While the block is active and `tx_mode_i` is high, each completed byte read from SDA is compared with `tx_byte_i`. Any mismatch sets `tx_err_o`.
- R10: START clears `coin_o`, `ext_o`, `gcall_o` and `tx_err_o`. STOP drops `active_o` and keeps the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| sva_we_i | input | 1 | Write strobe for the own-address register |
| sva_wdata_i | input | 8 | New own-address value, address in [7:1] |
| release_i | input | 1 | Withdraw from the current transfer |
| tx_mode_i | input | 1 | Local side is transmitting the current byte |
| tx_byte_i | input | 8 | Byte intended for transmission |
| irq_o | output | 1 | One-cycle interrupt on an accepted address byte |
| coin_o | output | 1 | Address coincidence flag |
| ext_o | output | 1 | Extension code flag |
| gcall_o | output | 1 | General call flag |
| tx_err_o | output | 1 | Transmit readback mismatch flag |
| active_o | output | 1 | Block is taking part in the transfer |
| sva_o | output | 8 | Own-address register contents |

## Verification
The assertions assume that SCL and SDA are already synchronous and glitch-free. They also assume that SDA changes only while SCL is low, except at START and STOP. Under those assumptions, a completed byte can never coincide with a START or STOP event. The bench holds every bus phase for four system clocks and changes a line only at a falling clock edge. This keeps every SCL edge, START and STOP as a clean, separate event. Flags and interrupt counts are read only after the phase that should have moved them has settled.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACTIVE,
        ST_STANDBY
    } am_state_e;

    typedef struct packed {
        logic coin;
        logic ext;
        logic gcall;
        logic txerr;
    } am_flags_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;

    function automatic logic is_ext_nibble(input logic [3:0] nib);
        return (nib == 4'b0000) || (nib == 4'b1111);
    endfunction

endpackage

// File: rtl/i2c_am_buscond.sv
module i2c_am_buscond
    import i2c_am_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        evt_o.rise  = scl_i & ~scl_q;
        evt_o.fall  = ~scl_i & scl_q;
        evt_o.start = scl_i & scl_q & sda_q & ~sda_i;
        evt_o.stop  = scl_i & scl_q & ~sda_q & sda_i;
    end

endmodule

// File: rtl/i2c_am_shifter.sv
module i2c_am_shifter #(
    parameter int DATA_W = 8,
    localparam int CW = $clog2(DATA_W + 1)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              clr_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              sda_i,
    output logic [DATA_W-1:0] byte_o,
    output logic              done_o
);

    logic [CW-1:0]     cnt_q;
    logic [DATA_W-1:0] shreg_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q   <= '0;
            shreg_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (rise_i) begin
            if (cnt_q == CW'(DATA_W)) begin
                cnt_q <= '0;
            end else begin
                shreg_q <= {shreg_q[DATA_W-2:0], sda_i};
                cnt_q   <= cnt_q + CW'(1);
            end
        end
    end

    assign byte_o = shreg_q;
    assign done_o = fall_i && (cnt_q == CW'(DATA_W));

    // R1
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= CW'(DATA_W));

endmodule

// File: rtl/i2c_am_decode.sv
module i2c_am_decode
    import i2c_am_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] rx_i,
    input  logic [DATA_W-2:0] own_addr_i,
    output logic              coin_o,
    output logic              ext_o,
    output logic              gcall_o
);

    assign coin_o  = (rx_i[DATA_W-1:1] == own_addr_i);
    assign ext_o   = is_ext_nibble(rx_i[DATA_W-1:DATA_W-4]);
    assign gcall_o = (rx_i == '0);

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_am_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              sva_we_i,
    input  logic [BYTE_W-1:0] sva_wdata_i,
    input  logic              release_i,
    input  logic              tx_mode_i,
    input  logic [BYTE_W-1:0] tx_byte_i,
    output logic              irq_o,
    output logic              coin_o,
    output logic              ext_o,
    output logic              gcall_o,
    output logic              tx_err_o,
    output logic              active_o,
    output logic [BYTE_W-1:0] sva_o
);

    bus_evt_t          evt;
    logic [BYTE_W-1:0] rx_byte;
    logic              byte_done;
    logic              dec_coin, dec_ext, dec_gcall;

    am_state_e         state_q;
    am_flags_t         flags_q;
    logic              irq_q;
    logic [BYTE_W-1:0] sva_q;

    i2c_am_buscond u_cond (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (evt)
    );

    i2c_am_shifter #(.DATA_W(BYTE_W)) u_shift (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .clr_i  (evt.start),
        .rise_i (evt.rise),
        .fall_i (evt.fall),
        .sda_i  (sda_i),
        .byte_o (rx_byte),
        .done_o (byte_done)
    );

    i2c_am_decode #(.DATA_W(BYTE_W)) u_dec (
        .rx_i       (rx_byte),
        .own_addr_i (sva_q[BYTE_W-1:1]),
        .coin_o     (dec_coin),
        .ext_o      (dec_ext),
        .gcall_o    (dec_gcall)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            flags_q <= '0;
            irq_q   <= 1'b0;
            sva_q   <= '0;
        end else begin
            irq_q <= 1'b0;
            if (sva_we_i) begin
                sva_q <= sva_wdata_i;
            end
            if (evt.start) begin
                state_q <= ST_ADDR;
                flags_q <= '0;
            end else if (release_i) begin
                state_q <= ST_STANDBY;
            end else if (evt.stop) begin
                state_q <= ST_IDLE;
            end else if (byte_done) begin
                case (state_q)
                    ST_ADDR: begin
                        flags_q.coin  <= dec_coin;
                        flags_q.ext   <= dec_ext;
                        flags_q.gcall <= dec_gcall;
                        if (dec_coin || dec_ext) begin
                            state_q <= ST_ACTIVE;
                            irq_q   <= 1'b1;
                        end else begin
                            state_q <= ST_STANDBY;
                        end
                    end
                    ST_ACTIVE: begin
                        if (tx_mode_i && (rx_byte != tx_byte_i)) begin
                            flags_q.txerr <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign irq_o    = irq_q;
    assign coin_o   = flags_q.coin;
    assign ext_o    = flags_q.ext;
    assign gcall_o  = flags_q.gcall;
    assign tx_err_o = flags_q.txerr;
    assign active_o = (state_q == ST_ACTIVE);
    assign sva_o    = sva_q;

    // R2
    irq_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_q |=> !irq_q);

    // R3
    irq_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_q |-> (flags_q.coin || flags_q.ext));

    // R4
    sva_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (byte_done && !sva_we_i) |=> $stable(sva_q));

    // R6
    gcall_ext_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        flags_q.gcall |-> flags_q.ext);

    // R7
    reject_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_ADDR && byte_done && !dec_coin && !dec_ext && !release_i)
        |=> (!irq_q && state_q == ST_STANDBY));

    // R8
    release_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        release_i |=> !active_o);

    // R10
    start_clr_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        evt.start |=> (flags_q == '0));

endmodule

// File: tb/i2c_addr_match_bench.sv
module i2c_addr_match_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic       sva_we = 1'b0;
    logic [7:0] sva_wdata = '0;
    logic       rel = 1'b0;
    logic       tx_mode = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       irq, coin, ext, gcall, tx_err, active;
    logic [7:0] sva;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    int irq_at_rise = 0;
    int irq_at_fall = 0;

    always #10 clk = ~clk;

    i2c_addr_match u_i2c_addr_match (
        .clk_i       (clk),
        .rst_i       (rst),
        .scl_i       (scl),
        .sda_i       (sda),
        .sva_we_i    (sva_we),
        .sva_wdata_i (sva_wdata),
        .release_i   (rel),
        .tx_mode_i   (tx_mode),
        .tx_byte_i   (tx_byte),
        .irq_o       (irq),
        .coin_o      (coin),
        .ext_o       (ext),
        .gcall_o     (gcall),
        .tx_err_o    (tx_err),
        .active_o    (active),
        .sva_o       (sva)
    );

    always @(posedge clk) begin
        if (rst) irq_cnt <= 0;
        else if (irq) irq_cnt <= irq_cnt + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold();
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_start();
        sda = 1'b1; hold();
        scl = 1'b1; hold();
        sda = 1'b0; hold();
        scl = 1'b0; hold();
    endtask

    task automatic bus_stop();
        sda = 1'b0; hold();
        scl = 1'b1; hold();
        sda = 1'b1; hold();
    endtask

    task automatic bus_bit(input logic b);
        sda = b;    hold();
        scl = 1'b1; hold();
        scl = 1'b0; hold();
    endtask

    task automatic bus_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) bus_bit(b[i]);
        bus_bit(1'b0);
    endtask

    task automatic addr_byte(input logic [7:0] b);
        for (int i = 7; i >= 1; i--) bus_bit(b[i]);
        sda = b[0]; hold();
        scl = 1'b1; hold();
        irq_at_rise = irq_cnt;
        scl = 1'b0; hold();
        irq_at_fall = irq_cnt;
        bus_bit(1'b0);
    endtask

    task automatic write_sva(input logic [7:0] v);
        @(negedge clk);
        sva_we = 1'b1; sva_wdata = v;
        @(negedge clk);
        sva_we = 1'b0;
    endtask

    task automatic t_reset();
        check("R10 reset coin", int'(coin), 0);
        check("R10 reset ext", int'(ext), 0);
        check("R7 reset active", int'(active), 0);
        check("R4 reset sva", int'(sva), 0);
        check("R2 reset irq", irq_cnt, 0);
    endtask

    task automatic t_match();
        int base;
        write_sva(8'h50);
        bus_start();
        base = irq_cnt;
        addr_byte(8'h50);
        check("R2 no irq at 8th rise", irq_at_rise, base);
        check("R2 irq after 8th fall", irq_at_fall, base + 1);
        check("R1 coin on match", int'(coin), 1);
        check("R3 no ext on plain address", int'(ext), 0);
        check("R7 active after match", int'(active), 1);
        bus_stop();
        check("R10 stop drops active", int'(active), 0);
        check("R10 flags kept after stop", int'(coin), 1);
        check("R2 one pulse only", irq_cnt, base + 1);
    endtask

    task automatic t_mismatch();
        int base;
        bus_start();
        base = irq_cnt;
        addr_byte(8'h52);
        check("R7 no irq on mismatch", irq_cnt, base);
        check("R7 no coin on mismatch", int'(coin), 0);
        check("R7 inactive on mismatch", int'(active), 0);
        bus_stop();
    endtask

    task automatic t_gcall();
        int base;
        bus_start();
        base = irq_cnt;
        addr_byte(8'h00);
        check("R6 gcall set", int'(gcall), 1);
        check("R3 ext on gcall", int'(ext), 1);
        check("R3 irq without match", irq_cnt, base + 1);
        check("R1 no coin on gcall", int'(coin), 0);
        check("R4 sva kept after gcall", int'(sva), 8'h50);
        bus_start();
        addr_byte(8'h01);
        check("R6 no gcall on read", int'(gcall), 0);
        check("R6 ext on 0x01", int'(ext), 1);
        bus_stop();
    endtask

    task automatic t_ext();
        bus_start();
        addr_byte(8'hF6);
        check("R3 ext on 1111 nibble", int'(ext), 1);
        check("R3 no coin", int'(coin), 0);
        check("R7 active on ext", int'(active), 1);
        check("R4 sva kept after ext", int'(sva), 8'h50);
        bus_stop();
    endtask

    task automatic t_tenbit();
        write_sva(8'hF2);
        bus_start();
        addr_byte(8'hF6);
        check("R5 partial ext", int'(ext), 1);
        check("R5 partial no coin", int'(coin), 0);
        bus_start();
        addr_byte(8'hF2);
        check("R5 full ext", int'(ext), 1);
        check("R5 full coin", int'(coin), 1);
        bus_start();
        check("R10 start clears coin", int'(coin), 0);
        check("R10 start clears ext", int'(ext), 0);
        addr_byte(8'hF3);
        check("R1 R/W ignored coin", int'(coin), 1);
        check("R5 read header ext", int'(ext), 1);
        check("R4 sva kept 10-bit", int'(sva), 8'hF2);
        bus_stop();
    endtask

    task automatic t_release();
        write_sva(8'h50);
        bus_start();
        addr_byte(8'h00);
        check("R7 active before release", int'(active), 1);
        @(negedge clk); rel = 1'b1;
        @(negedge clk); rel = 1'b0;
        check("R8 release drops active", int'(active), 0);
        check("R8 flags kept on release", int'(ext), 1);
        tx_mode = 1'b1; tx_byte = 8'hFF;
        bus_byte(8'h00);
        check("R8 no tx check after release", int'(tx_err), 0);
        check("R8 still inactive", int'(active), 0);
        tx_mode = 1'b0;
        bus_start();
        addr_byte(8'h50);
        check("R8 new start reactivates", int'(active), 1);
        bus_stop();
    endtask

    task automatic t_tx();
        bus_start();
        addr_byte(8'h50);
        tx_mode = 1'b1; tx_byte = 8'hA5;
        bus_byte(8'hA5);
        check("R9 equal byte no error", int'(tx_err), 0);
        bus_byte(8'h25);
        check("R9 mismatch sets error", int'(tx_err), 1);
        tx_mode = 1'b0;
        bus_stop();
        check("R10 tx_err kept after stop", int'(tx_err), 1);
        bus_start();
        check("R10 start clears tx_err", int'(tx_err), 0);
        bus_stop();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_match();
        t_mismatch();
        t_gcall();
        t_ext();
        t_tenbit();
        t_release();
        t_tx();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule